// File: doc/BRIEF.md
# Clear-to-Send Transmit Gate

This block decides, for one transmit channel, when a new message may begin and when the line must carry idle fill instead of message data. It watches a clear-to-send level, samples it on a chosen edge of the transmit clock, and counts bit strobes from the transmitter after the level is withdrawn.

Withdrawal never cuts a message short. A message that is already under way runs to its end marker. A message that begins within a 32-bit-time grace period after withdrawal is still accepted. Once the grace period has run out and no message is in progress, the block selects continuous idle characters. When clear-to-send comes back, the permit returns and idle fill is released.

The transmitter asks for a start with `msg_start` only while `start_ok` is high. It marks the last bit of a message with `msg_end`, and uses `idle_fill` to steer its output multiplexer toward the idle-character source.

Top module: `cts_tx_gate`

## Requirements
- R1: After synchronous reset, `start_ok` is 1 and `idle_fill` is 0. During reset, clear-to-send is taken as asserted.
- R2: With `edge_sel`=0, `cts` is sampled on the rising clock edge and then re-registered. With `edge_sel`=1, it is sampled on the falling edge. The falling-edge path takes effect one rising edge earlier than the rising-edge path.
- R3: After the sampled clear-to-send goes low, `start_ok` stays 1 until 32 bit strobes have been counted. It falls on the rising edge that registers the 32nd strobe. With a strobe on every cycle and `edge_sel`=0, that is the 34th rising edge after the edge before the drop.
- R4: Only cycles with `bit_stb`=1 advance the grace count. With no strobes, `start_ok` stays 1 for as long as the level is withdrawn.
- R5: A `msg_start` that the clock edge samples while `start_ok` is 1 is accepted. This holds even on the last grace cycle, and the accepted message stays in progress until `msg_end`.
- R6: `idle_fill` is 1 exactly when `start_ok` is 0 and no message is in progress. It rises on the edge where the permit drops, or, if a message is still in progress then, on the edge that samples that message's `msg_end`.
- R7: A `msg_start` sampled while `start_ok` is 0 is ignored, and `idle_fill` stays 1.
- R8: If clear-to-send returns inside the grace period, the count is cleared and `start_ok` never falls. A later withdrawal gets a full 32-strobe grace period.
- R9: When the sampled clear-to-send returns high, `start_ok` goes to 1 and `idle_fill` goes to 0 one rising edge later. With `edge_sel`=0, that is the third rising edge after the change.
- R10: When `msg_start` and `msg_end` are both 1 in a cycle where a start would be accepted, the new start wins and a message stays in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_sel | input | 1 | 0: sample `cts` on the rising edge, 1: sample on the falling edge |
| cts | input | 1 | Clear-to-send level, 1 = clear |
| bit_stb | input | 1 | One pulse per transmitted bit time |
| msg_start | input | 1 | Transmitter requests the start of a message |
| msg_end | input | 1 | Transmitter marks the last bit of a message |
| start_ok | output | 1 | A new message may start |
| idle_fill | output | 1 | Select idle characters for the line |

## Verification
The closest collision is a message start that lands on the very rising edge where the grace count reaches 32 and the permit falls. The bench withdraws clear-to-send, waits 33 edges with strobes on every cycle, and raises `msg_start` for exactly the next edge. It then expects `start_ok` low but `idle_fill` still low, and `idle_fill` rising only on the edge that samples the later `msg_end`. A second collision, a start and an end in the same cycle during the grace period, is provoked the same way and judged by `idle_fill` staying low after the permit has dropped.

// File: rtl/cts_gate_pkg.sv
package cts_gate_pkg;
  typedef enum logic {
    SAMPLE_RISE = 1'b0,
    SAMPLE_FALL = 1'b1
  } sample_edge_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/cts_edge_sampler.sv
module cts_edge_sampler
  import cts_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic edge_sel,
  input  logic cts,
  output logic cts_q
);
  logic s_rise;
  logic s_fall;

  always_ff @(posedge clk) begin
    if (rst) s_rise <= 1'b1;
    else     s_rise <= cts;
  end

  always_ff @(negedge clk) begin
    if (rst) s_fall <= 1'b1;
    else     s_fall <= cts;
  end

  always_ff @(posedge clk) begin
    if (rst) cts_q <= 1'b1;
    else     cts_q <= (sample_edge_e'(edge_sel) == SAMPLE_FALL) ? s_fall : s_rise;
  end
endmodule

// File: rtl/cts_grace_counter.sv
module cts_grace_counter #(
  parameter int unsigned GRACE_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_q,
  input  logic bit_stb,
  output logic start_ok,
  output logic permit_nxt
);
  localparam int unsigned CW = cts_gate_pkg::cnt_width(GRACE_BITS);
  localparam logic [CW-1:0] LIMIT = CW'(GRACE_BITS);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (cts_q)                         cnt_nxt = '0;
    else if (bit_stb && cnt != LIMIT)  cnt_nxt = cnt + 1'b1;
    permit_nxt = cts_q || (cnt_nxt != LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      start_ok <= 1'b1;
    end else begin
      cnt      <= cnt_nxt;
      start_ok <= permit_nxt;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

  assert_stb_only_R4: assert property (@(posedge clk) disable iff (rst)
    (!bit_stb && !cts_q) |=> $stable(cnt));

  assert_resume_R9: assert property (@(posedge clk) disable iff (rst)
    cts_q |=> (start_ok && cnt == '0));
endmodule

// File: rtl/cts_msg_tracker.sv
module cts_msg_tracker (
  input  logic clk,
  input  logic rst,
  input  logic start_ok,
  input  logic permit_nxt,
  input  logic msg_start,
  input  logic msg_end,
  output logic idle_fill
);
  logic busy;
  logic busy_nxt;
  logic accept;

  always_comb begin
    accept   = msg_start && start_ok;
    busy_nxt = accept || (busy && !msg_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      idle_fill <= 1'b0;
    end else begin
      busy      <= busy_nxt;
      idle_fill <= !permit_nxt && !busy_nxt;
    end
  end

  assert_busy_no_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !msg_end) |=> !idle_fill);

  assert_late_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (msg_start && !start_ok && !busy) |=> !busy);

  assert_start_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (msg_start && msg_end && start_ok) |=> busy);
endmodule

// File: rtl/cts_tx_gate.sv
module cts_tx_gate #(
  parameter int unsigned GRACE_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_sel,
  input  logic cts,
  input  logic bit_stb,
  input  logic msg_start,
  input  logic msg_end,
  output logic start_ok,
  output logic idle_fill
);
  logic cts_q;
  logic permit_nxt;

  cts_edge_sampler u_sampler (
    .clk      (clk),
    .rst      (rst),
    .edge_sel (edge_sel),
    .cts      (cts),
    .cts_q    (cts_q)
  );

  cts_grace_counter #(.GRACE_BITS(GRACE_BITS)) u_grace (
    .clk        (clk),
    .rst        (rst),
    .cts_q      (cts_q),
    .bit_stb    (bit_stb),
    .start_ok   (start_ok),
    .permit_nxt (permit_nxt)
  );

  cts_msg_tracker u_track (
    .clk        (clk),
    .rst        (rst),
    .start_ok   (start_ok),
    .permit_nxt (permit_nxt),
    .msg_start  (msg_start),
    .msg_end    (msg_end),
    .idle_fill  (idle_fill)
  );

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (start_ok && !idle_fill));

  assert_idle_needs_no_permit_R6: assert property (@(posedge clk) disable iff (rst)
    idle_fill |-> !start_ok);
endmodule

// File: tb/tb_cts_tx_gate.sv
module tb_cts_tx_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic edge_sel = 1'b0;
  logic cts = 1'b1;
  logic bit_stb = 1'b1;
  logic msg_start = 1'b0;
  logic msg_end = 1'b0;
  logic start_ok;
  logic idle_fill;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  so;
    logic  idl;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  event sb_ev;

  always #2 clk = ~clk;

  cts_tx_gate dut (
    .clk       (clk),
    .rst       (rst),
    .edge_sel  (edge_sel),
    .cts       (cts),
    .bit_stb   (bit_stb),
    .msg_start (msg_start),
    .msg_end   (msg_end),
    .start_ok  (start_ok),
    .idle_fill (idle_fill)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic so, input logic idl, input string tag);
    exp_t e;
    e.so = so;
    e.idl = idl;
    e.tag = tag;
    sb_q.push_back(e);
    -> sb_ev;
  endtask

  task automatic drain();
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (start_ok !== e.so || idle_fill !== e.idl) begin
        errors++;
        $display("FAIL %s: start_ok=%b idle_fill=%b expected start_ok=%b idle_fill=%b",
                 e.tag, start_ok, idle_fill, e.so, e.idl);
      end
    end
  endtask

  initial begin
    forever begin
      @(sb_ev);
      drain();
    end
  end

  task automatic restore();
    cts = 1'b1;
    tick(4);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    expect_out(1'b1, 1'b0, "R1 reset state");

    // R3 / R6: grace window with no message in progress
    cts = 1'b0;
    tick(33);
    expect_out(1'b1, 1'b0, "R3 last grace cycle");
    tick(1);
    expect_out(1'b0, 1'b1, "R3 R6 permit drop with idle");

    // R7: start after the window is ignored
    msg_start = 1'b1;
    tick(1);
    msg_start = 1'b0;
    tick(2);
    expect_out(1'b0, 1'b1, "R7 late start ignored");

    // R9: resume
    cts = 1'b1;
    tick(2);
    expect_out(1'b0, 1'b1, "R9 before resume");
    tick(1);
    expect_out(1'b1, 1'b0, "R9 resumed");

    // R8: return inside the window
    cts = 1'b0;
    tick(10);
    cts = 1'b1;
    tick(40);
    expect_out(1'b1, 1'b0, "R8 permit kept");
    cts = 1'b0;
    tick(33);
    expect_out(1'b1, 1'b0, "R8 full window again");
    tick(1);
    expect_out(1'b0, 1'b1, "R8 drop after full window");
    restore();

    // R5 / R6: start on the last grace cycle
    cts = 1'b0;
    tick(33);
    msg_start = 1'b1;
    tick(1);
    msg_start = 1'b0;
    expect_out(1'b0, 1'b0, "R5 start on last grace edge");
    tick(6);
    expect_out(1'b0, 1'b0, "R6 idle held off by message");
    msg_end = 1'b1;
    tick(1);
    msg_end = 1'b0;
    expect_out(1'b0, 1'b1, "R6 idle after end");
    restore();

    // R5: message begun before withdrawal runs to its end
    msg_start = 1'b1;
    tick(1);
    msg_start = 1'b0;
    cts = 1'b0;
    tick(40);
    expect_out(1'b0, 1'b0, "R5 message runs on");
    msg_end = 1'b1;
    tick(1);
    msg_end = 1'b0;
    expect_out(1'b0, 1'b1, "R5 idle after straddling end");
    restore();

    // R10: start and end in the same accepted cycle
    msg_start = 1'b1;
    tick(1);
    msg_start = 1'b0;
    cts = 1'b0;
    tick(5);
    msg_start = 1'b1;
    msg_end = 1'b1;
    tick(1);
    msg_start = 1'b0;
    msg_end = 1'b0;
    tick(40);
    expect_out(1'b0, 1'b0, "R10 start wins over end");
    msg_end = 1'b1;
    tick(1);
    msg_end = 1'b0;
    expect_out(1'b0, 1'b1, "R10 idle after final end");
    restore();

    // R4: only strobes advance the count
    bit_stb = 1'b0;
    cts = 1'b0;
    tick(100);
    expect_out(1'b1, 1'b0, "R4 no strobes keeps permit");
    bit_stb = 1'b1;
    tick(31);
    expect_out(1'b1, 1'b0, "R4 31 strobes");
    tick(1);
    expect_out(1'b0, 1'b1, "R4 32 strobes");
    restore();

    // R2: falling-edge sampling is one edge earlier
    edge_sel = 1'b1;
    tick(4);
    cts = 1'b0;
    tick(32);
    expect_out(1'b1, 1'b0, "R2 fall-sampled last grace cycle");
    tick(1);
    expect_out(1'b0, 1'b1, "R2 fall-sampled drop");

    tick(2);
    drain();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule